// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Interrupts

This block gives the two ports of a shared dual-port memory a hardware doorbell. Two reserved addresses at the top of the address space act as mailboxes, one per direction. The highest address carries messages toward the right port, and the address one below it carries messages toward the left port. When one side writes its outgoing mailbox, the receiving side sees an active-low interrupt flag. The receiving side lowers its own flag again by reading that same mailbox. The flag stays low until that read happens.

The block watches each port's select, write strobe, output enable and address. It registers the two flags on the rising clock edge, so a qualifying access in one cycle shows on the flag after that edge. Data storage, the open-drain pad driver and same-address arbitration sit outside this block. The flag pins here are plain logic outputs, where low means asserted.

Top module: `mbox_irq_top`

## Requirements
- R1: After a synchronous reset, `left_irq_n` and `right_irq_n` are both 1 (deasserted).
- R2: A left-port write (`left_sel`=1, `left_wr`=1) to the all-ones address (0x3FF at the default width) drives `right_irq_n` to 0 on the next clock edge.
- R3: A right-port write (`right_sel`=1, `right_wr`=1) to the all-ones-minus-one address (0x3FE) drives `left_irq_n` to 0 on the next clock edge.
- R4: A right-port read (`right_sel`=1, `right_wr`=0, `right_oe`=1) of address 0x3FF drives `right_irq_n` to 1 on the next clock edge.
- R5: A left-port read (`left_sel`=1, `left_wr`=0, `left_oe`=1) of address 0x3FE drives `left_irq_n` to 1 on the next clock edge.
- R6: A flag is set only when select, write and the matching address are all present in the same cycle. If any one of them is missing, the flag does not change.
- R7: A flag is cleared only when select, output enable, read (`wr`=0) and the matching address are all present in the same cycle. If any one of them is missing, the flag does not change.
- R8: A flag keeps its value after the access that set or cleared it has ended.
- R9: If a set and a clear reach the same flag in the same cycle, the flag is 0 after that edge. The set wins.
- R10: A port that reads or writes its own outgoing mailbox does not change its own flag. A port that reads its outgoing mailbox does not clear the other port's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| left_sel | input | 1 | Left port select, active high |
| left_wr | input | 1 | Left port direction, 1 = write, 0 = read |
| left_oe | input | 1 | Left port output enable, active high |
| left_addr | input | ADDR_W | Left port address |
| right_sel | input | 1 | Right port select, active high |
| right_wr | input | 1 | Right port direction, 1 = write, 0 = read |
| right_oe | input | 1 | Right port output enable, active high |
| right_addr | input | ADDR_W | Right port address |
| left_irq_n | output | 1 | Interrupt toward left port, 0 = asserted |
| right_irq_n | output | 1 | Interrupt toward right port, 0 = asserted |

## Verification
The hardest case to reach is a collision on one flag: one port rings the doorbell in the same cycle that the receiver is acknowledging it. Reaching it takes coordinated stimulus on both ports at once. The stimulus drives a left write to 0x3FF and a full right read of 0x3FF in the same cycle. It does this once from a deasserted flag and once from an asserted flag, and the flag must be low after both. The qualifier tests hold the flag in a known state and then remove one term at a time, so that a missing term shows up as an unwanted change on the output pin.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;

  // Mailbox address whose write raises the flag of port 'dst'.
  function automatic logic [31:0] doorbell_addr(input int addr_w, input int dst);
    logic [31:0] top;
    top = (32'd1 << addr_w) - 32'd1;
    return (dst == PORT_R) ? top : top - 32'd1;
  endfunction
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OUT_ADDR = '1,
  parameter logic [ADDR_W-1:0] IN_ADDR = '0
) (
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  output logic              ring_o,
  output logic              ack_o
);
  // ring: write to the mailbox aimed at the peer
  // ack: qualified read of the mailbox aimed at this port
  always_comb begin
    ring_o = sel && wr && (addr == OUT_ADDR);
    ack_o  = sel && !wr && oe && (addr == IN_ADDR);
  end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_n_o <= 1'b1;
    else if (set_i) irq_n_o <= 1'b0;
    else if (clr_i) irq_n_o <= 1'b1;
  end

  assert_set_lowers_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> !irq_n_o);
  assert_clear_raises_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> irq_n_o);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(irq_n_o));
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> irq_n_o);
endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              left_sel,
  input  logic              left_wr,
  input  logic              left_oe,
  input  logic [ADDR_W-1:0] left_addr,
  input  logic              right_sel,
  input  logic              right_wr,
  input  logic              right_oe,
  input  logic [ADDR_W-1:0] right_addr,
  output logic              left_irq_n,
  output logic              right_irq_n
);
  import mbox_irq_pkg::*;

  localparam logic [ADDR_W-1:0] BOX_TO_L = ADDR_W'(doorbell_addr(ADDR_W, PORT_L));
  localparam logic [ADDR_W-1:0] BOX_TO_R = ADDR_W'(doorbell_addr(ADDR_W, PORT_R));

  logic [NUM_PORTS-1:0]             sel_v, wr_v, oe_v, ring_v, ack_v, irq_n_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;

  always_comb begin
    sel_v  = {right_sel, left_sel};
    wr_v   = {right_wr, left_wr};
    oe_v   = {right_oe, left_oe};
    addr_v = {right_addr, left_addr};
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OUT_A = (p == PORT_L) ? BOX_TO_R : BOX_TO_L;
    localparam logic [ADDR_W-1:0] IN_A  = (p == PORT_L) ? BOX_TO_L : BOX_TO_R;

    mbox_port_decode #(.ADDR_W(ADDR_W), .OUT_ADDR(OUT_A), .IN_ADDR(IN_A)) u_dec (
      .sel(sel_v[p]), .wr(wr_v[p]), .oe(oe_v[p]), .addr(addr_v[p]),
      .ring_o(ring_v[p]), .ack_o(ack_v[p])
    );

    mbox_irq_flag u_flag (
      .clk(clk), .rst(rst),
      .set_i(ring_v[NUM_PORTS-1-p]), .clr_i(ack_v[p]),
      .irq_n_o(irq_n_v[p])
    );
  end

  assign left_irq_n  = irq_n_v[PORT_L];
  assign right_irq_n = irq_n_v[PORT_R];

  // Port-level checks
  assert_left_rings_right_R2: assert property (@(posedge clk) disable iff (rst)
    (left_sel && left_wr && left_addr == BOX_TO_R) |=> !right_irq_n);
  assert_right_rings_left_R3: assert property (@(posedge clk) disable iff (rst)
    (right_sel && right_wr && right_addr == BOX_TO_L) |=> !left_irq_n);
  assert_own_box_no_effect_R10: assert property (@(posedge clk) disable iff (rst)
    (left_sel && left_addr == BOX_TO_R && !(right_sel && right_wr && right_addr == BOX_TO_L))
      |=> $stable(left_irq_n));
endmodule

// File: tb/mbox_irq_top_tb_top.sv
module mbox_irq_top_tb_top;
  localparam int AW = 10;
  localparam logic [AW-1:0] A_TO_R = 10'h3FF;
  localparam logic [AW-1:0] A_TO_L = 10'h3FE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_wr = 0, l_oe = 0, r_sel = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mbox_irq_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .left_sel(l_sel), .left_wr(l_wr), .left_oe(l_oe), .left_addr(l_addr),
    .right_sel(r_sel), .right_wr(r_wr), .right_oe(r_oe), .right_addr(r_addr),
    .left_irq_n(l_irq_n), .right_irq_n(r_irq_n)
  );

  task automatic idle();
    l_sel = 0; l_wr = 0; l_oe = 0; l_addr = '0;
    r_sel = 0; r_wr = 0; r_oe = 0; r_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic lacc(input logic s, input logic w, input logic o, input logic [AW-1:0] a);
    l_sel = s; l_wr = w; l_oe = o; l_addr = a;
  endtask
  task automatic racc(input logic s, input logic w, input logic o, input logic [AW-1:0] a);
    r_sel = s; r_wr = w; r_oe = o; r_addr = a;
  endtask

  task automatic t_reset();
    chk("R1 left", l_irq_n, 1'b1);
    chk("R1 right", r_irq_n, 1'b1);
  endtask

  task automatic t_left_to_right();
    lacc(1, 1, 0, A_TO_R); step(); idle();
    chk("R2 right set", r_irq_n, 1'b0);
    chk("R10 left unchanged", l_irq_n, 1'b1);
    step(); step();
    chk("R8 right held low", r_irq_n, 1'b0);
    racc(1, 0, 1, A_TO_R); step(); idle();
    chk("R4 right cleared", r_irq_n, 1'b1);
    step();
    chk("R8 right held high", r_irq_n, 1'b1);
  endtask

  task automatic t_right_to_left();
    racc(1, 1, 0, A_TO_L); step(); idle();
    chk("R3 left set", l_irq_n, 1'b0);
    chk("R10 right unchanged", r_irq_n, 1'b1);
    step();
    lacc(1, 0, 1, A_TO_L); step(); idle();
    chk("R5 left cleared", l_irq_n, 1'b1);
  endtask

  task automatic t_set_terms();
    lacc(0, 1, 0, A_TO_R); step(); idle();
    chk("R6 no sel", r_irq_n, 1'b1);
    lacc(1, 0, 0, A_TO_R); step(); idle();
    chk("R6 no write", r_irq_n, 1'b1);
    lacc(1, 1, 0, 10'h3FD); step(); idle();
    chk("R6 wrong addr", r_irq_n, 1'b1);
    racc(1, 1, 0, 10'h17F); step(); idle();
    chk("R6 right wrong addr", l_irq_n, 1'b1);
  endtask

  task automatic t_clear_terms();
    lacc(1, 1, 0, A_TO_R); step(); idle();
    chk("R2 preset", r_irq_n, 1'b0);
    racc(1, 0, 0, A_TO_R); step(); idle();
    chk("R7 no oe", r_irq_n, 1'b0);
    racc(0, 0, 1, A_TO_R); step(); idle();
    chk("R7 no sel", r_irq_n, 1'b0);
    racc(1, 1, 1, A_TO_R); step(); idle();
    chk("R7 write not read", r_irq_n, 1'b0);
    racc(1, 0, 1, A_TO_L); step(); idle();
    chk("R7 wrong addr", r_irq_n, 1'b0);
    racc(1, 0, 1, A_TO_R); step(); idle();
    chk("R4 final clear", r_irq_n, 1'b1);
  endtask

  task automatic t_collision();
    lacc(1, 1, 0, A_TO_R); racc(1, 0, 1, A_TO_R); step(); idle();
    chk("R9 from high", r_irq_n, 1'b0);
    lacc(1, 1, 0, A_TO_R); racc(1, 0, 1, A_TO_R); step(); idle();
    chk("R9 from low", r_irq_n, 1'b0);
    racc(1, 1, 0, A_TO_L); lacc(1, 0, 1, A_TO_L); step(); idle();
    chk("R9 left side", l_irq_n, 1'b0);
  endtask

  task automatic t_own_box();
    // both flags low here
    lacc(1, 0, 1, A_TO_R); step(); idle();
    chk("R10 left read own out: left", l_irq_n, 1'b0);
    chk("R10 left read own out: right", r_irq_n, 1'b0);
    racc(1, 0, 1, A_TO_L); step(); idle();
    chk("R10 right read own out: right", r_irq_n, 1'b0);
    chk("R10 right read own out: left", l_irq_n, 1'b0);
    lacc(1, 0, 1, A_TO_L); racc(1, 0, 1, A_TO_R); step(); idle();
    chk("R5 both clear left", l_irq_n, 1'b1);
    chk("R4 both clear right", r_irq_n, 1'b1);
    lacc(1, 1, 0, A_TO_R); step(); idle();
    chk("R10 left write own out: left", l_irq_n, 1'b1);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_set_terms();
    t_clear_terms();
    t_collision();
    t_own_box();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule